// File: doc/BRIEF.md
# I2C Passive Bus Monitor

This block listens to an I2C bus without ever driving it. It brings SCL and SDA into the system clock domain and finds START and STOP conditions. It then collects each 9-bit word on the bus: eight data bits, most significant first, followed by the acknowledge bit. The first word after a START is the address byte. Its upper seven bits are compared against four programmable slot values. When match-all is enabled, any address is accepted.

Once an address hits, the monitor raises an interrupt for the address word and for every following byte. It shows the byte in a data register and the whole 9-bit word in a buffer register. This holds even when the byte was driven onto the bus by a different slave that answered a read. The monitor sends no acknowledge and never holds the clock low. Any arbitration mismatch between what it would have sent and what is on the bus is ignored.

Software, or a neighbouring block, programs the four slots and the mode inputs. It waits for the interrupt, reads the data or buffer output, and clears the flag with a one-cycle pulse.

Top module: `i2c_bus_monitor`

## Requirements
- R1: After reset, irq_o, matched_o and dir_o are 0, data_o reads 0x00 and buf_o reads 0x000.
- R2: With mon_en_i high, an address byte whose bits 7:1 equal bits 7:1 of a nonzero slot sets matched_o and raises irq_o. The address byte then appears on data_o, and dir_o takes the byte's bit 0 (1 = read).
- R3: A slot that holds 0x00 matches nothing. An address that hits no slot leaves irq_o and matched_o at 0, and data_o and buf_o unchanged.
- R4: Bit 0 of a slot is a general-call enable. When it is set, the address byte 0x00 matches that slot. When no slot has it set, 0x00 does not match (unless match-all is on).
- R5: With mon_en_i and match_all_i both high, every address byte matches.
- R6: With mon_en_i low, no address matches, irq_o never rises and matched_o stays 0, whatever match_all_i is.
- R7: After a match, each completed 9-bit word raises irq_o. data_o takes the eight data bits, and buf_o takes {data, ack}, with buf_o[0] = the sampled ninth bit (0 = ACK). Both outputs change only when a ninth bit completes.
- R8: In a read transfer, data_o holds the byte actually seen on SDA. A NACK (ninth bit 1) on a read data byte stops reporting, so no interrupt and no data update happen until the next START.
- R9: A STOP (SDA rising while SCL is high) clears matched_o. A repeated START (SDA falling while SCL is high) restarts address capture.
- R10: Once set, irq_o stays high until a one-cycle irq_clr_i pulse clears it. If a new event and the clear arrive in the same cycle, the event wins.
- R11: scl_oe_o and sda_oe_o are always 0, so the block never pulls either line low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| mon_en_i | input | 1 | Monitor enable |
| match_all_i | input | 1 | Accept any address (only when monitor is enabled) |
| slot_i | input | 32 | Four address slots, slot k at bits 8k+7:8k; bits 7:1 address, bit 0 general-call enable |
| irq_clr_i | input | 1 | One-cycle interrupt clear |
| irq_o | output | 1 | Sticky interrupt flag |
| matched_o | output | 1 | Address matched in the current transaction |
| dir_o | output | 1 | Direction bit of the matched address (1 = read) |
| data_o | output | 8 | Last reported byte |
| buf_o | output | 9 | Last reported word: byte in bits 8:1, ack bit in bit 0 |
| scl_oe_o | output | 1 | SCL pull-down enable, always 0 |
| sda_oe_o | output | 1 | SDA pull-down enable, always 0 |

## Verification
Four kinds of address are sent: one that hits a programmed slot, one that hits no slot, the general-call byte with and without a slot enabling it, and an arbitrary address under match-all. Together they separate the slot compare, the zero-slot exclusion, the general-call path and the match-all override. Write transfers with ACK and read transfers ending in NACK show whether the ninth bit lands in the buffer and whether reporting stops after a NACK. A repeated START and a STOP check that the matched state is restarted and dropped. The same address is also sent with the monitor disabled and match-all high, to confirm that the enable gates everything.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = BYTE_W + 1;
  typedef enum logic {PH_ADDR, PH_DATA} phase_e;
endpackage

// File: rtl/i2c_mon_sync.sv
module i2c_mon_sync #(
  parameter int unsigned W = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1; // idle bus is high
    else begin
      pipe_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/i2c_mon_cond.sv
module i2c_mon_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o    = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_o     = scl_q & scl_i & ~sda_q & sda_i;
  assign scl_rise_o = ~scl_q & scl_i;
endmodule

// File: rtl/i2c_mon_addr_match.sv
module i2c_mon_addr_match #(
  parameter int unsigned SLOTS = 4,
  parameter int unsigned BW = 8
) (
  input  logic [BW-1:0]            addr_byte_i,
  input  logic [SLOTS-1:0][BW-1:0] slot_i,
  input  logic                     match_all_i,
  output logic                     hit_o
);
  logic [SLOTS-1:0] slot_hit;
  logic             is_gcall;

  assign is_gcall = (addr_byte_i[BW-1:1] == '0);

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic live;
    assign live        = (slot_i[k] != '0);
    assign slot_hit[k] = live & (is_gcall ? slot_i[k][0]
                                          : (slot_i[k][BW-1:1] == addr_byte_i[BW-1:1]));
  end

  assign hit_o = match_all_i | (|slot_hit);
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
  import i2c_mon_pkg::*;
#(
  parameter int unsigned SLOTS = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         scl_i,
  input  logic                         sda_i,
  input  logic                         mon_en_i,
  input  logic                         match_all_i,
  input  logic [SLOTS-1:0][BYTE_W-1:0] slot_i,
  input  logic                         irq_clr_i,
  output logic                         irq_o,
  output logic                         matched_o,
  output logic                         dir_o,
  output logic [BYTE_W-1:0]            data_o,
  output logic [WORD_W-1:0]            buf_o,
  output logic                         scl_oe_o,
  output logic                         sda_oe_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic scl_s, sda_s, start_det, stop_det, scl_rise;
  logic addr_hit, word_done, irq_set;

  i2c_mon_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({scl_i, sda_i}), .q_o({scl_s, sda_s})
  );

  i2c_mon_cond u_cond (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_s), .sda_i(sda_s),
    .start_o(start_det), .stop_o(stop_det), .scl_rise_o(scl_rise)
  );

  logic              active_q, rpt_q, matched_q, dir_q, irq_q;
  phase_e            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q, data_q;
  logic [WORD_W-1:0] buf_q;

  i2c_mon_addr_match #(.SLOTS(SLOTS), .BW(BYTE_W)) u_match (
    .addr_byte_i(sh_q), .slot_i(slot_i), .match_all_i(match_all_i & mon_en_i), .hit_o(addr_hit)
  );

  assign word_done = active_q & scl_rise & (cnt_q == LAST_BIT) & ~start_det & ~stop_det;
  assign irq_set   = word_done & mon_en_i &
                     (((phase_q == PH_ADDR) & addr_hit) | ((phase_q == PH_DATA) & rpt_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      rpt_q     <= 1'b0;
      matched_q <= 1'b0;
      dir_q     <= 1'b0;
      phase_q   <= PH_ADDR;
      cnt_q     <= '0;
      sh_q      <= '0;
      data_q    <= '0;
      buf_q     <= '0;
    end else if (start_det) begin
      active_q  <= 1'b1;
      phase_q   <= PH_ADDR;
      cnt_q     <= '0;
      matched_q <= 1'b0;
      rpt_q     <= 1'b0;
    end else if (stop_det) begin
      active_q  <= 1'b0;
      matched_q <= 1'b0;
      rpt_q     <= 1'b0;
    end else if (active_q && scl_rise) begin
      if (cnt_q == LAST_BIT) begin
        cnt_q <= '0;
        if (phase_q == PH_ADDR) begin
          phase_q   <= PH_DATA;
          matched_q <= irq_set;
          rpt_q     <= irq_set;
          if (irq_set) dir_q <= sh_q[0];
        end else if (irq_set && dir_q && sda_s) begin
          rpt_q <= 1'b0; // NACK on read: stop reporting
        end
        if (irq_set) begin
          data_q <= sh_q;
          buf_q  <= {sh_q, sda_s};
        end
      end else begin
        sh_q  <= {sh_q[BYTE_W-2:0], sda_s};
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_q <= 1'b0;
    else if (irq_set)   irq_q <= 1'b1;
    else if (irq_clr_i) irq_q <= 1'b0;
  end

  assign irq_o     = irq_q;
  assign matched_o = matched_q;
  assign dir_o     = dir_q;
  assign data_o    = data_q;
  assign buf_o     = buf_q;
  assign scl_oe_o  = 1'b0;
  assign sda_oe_o  = 1'b0;

  assert_irq_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o);
  assert_irq_from_word_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(word_done));
  assert_data_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_done |=> ($stable(data_o) && $stable(buf_o)));
  assert_stop_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !matched_o);
  assert_off_no_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mon_en_i |=> !$rose(matched_o));
endmodule

// File: tb/i2c_bus_monitor_bench.sv
module i2c_bus_monitor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, mon_en = 1'b0, match_all = 1'b0, irq_clr = 1'b0;
  logic [3:0][7:0] slots = '0;
  logic irq, matched, dir, scl_oe, sda_oe;
  logic [7:0] data;
  logic [8:0] bufw;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_bus_monitor u_i2c_bus_monitor (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda), .mon_en_i(mon_en),
    .match_all_i(match_all), .slot_i(slots), .irq_clr_i(irq_clr), .irq_o(irq),
    .matched_o(matched), .dir_o(dir), .data_o(data), .buf_o(bufw),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda = 1'b1; wait_clk(H); scl = 1'b1; wait_clk(H);
    sda = 1'b0; wait_clk(H); scl = 1'b0; wait_clk(2);
  endtask

  task automatic bus_stop();
    sda = 1'b0; wait_clk(H); scl = 1'b1; wait_clk(H); sda = 1'b1; wait_clk(H);
  endtask

  task automatic bus_bit(input logic b);
    sda = b; wait_clk(H); scl = 1'b1; wait_clk(H); scl = 1'b0; wait_clk(2);
  endtask

  task automatic bus_word(input logic [7:0] v, input logic ack);
    for (int i = 7; i >= 0; i--) bus_bit(v[i]);
    bus_bit(ack);
  endtask

  task automatic clear_irq();
    irq_clr = 1'b1; wait_clk(1); irq_clr = 1'b0; wait_clk(1);
  endtask

  task automatic t_reset();
    chk("R1 irq", irq, 0); chk("R1 matched", matched, 0); chk("R1 dir", dir, 0);
    chk("R1 data", data, 0); chk("R1 buf", bufw, 0);
  endtask

  task automatic t_write_match();
    bus_start();
    bus_word(8'hA0, 1'b0);
    chk("R2 irq", irq, 1); chk("R2 matched", matched, 1); chk("R2 dir", dir, 0);
    chk("R2 data", data, 8'hA0);
    chk("R7 buf addr word", bufw, 9'h140);
    wait_clk(20);
    chk("R10 irq held", irq, 1);
    clear_irq();
    chk("R10 irq cleared", irq, 0);
    bus_word(8'h3C, 1'b0);
    chk("R7 irq data", irq, 1); chk("R7 data", data, 8'h3C); chk("R7 buf", bufw, 9'h078);
    clear_irq();
    bus_word(8'hC5, 1'b1);
    chk("R7 irq second", irq, 1); chk("R7 buf nack bit", bufw, 9'h18B);
    clear_irq();
    bus_stop();
    chk("R9 stop clears matched", matched, 0);
    chk("R11 scl_oe", scl_oe, 0); chk("R11 sda_oe", sda_oe, 0);
  endtask

  task automatic t_no_match();
    bus_start();
    bus_word(8'h44, 1'b0);
    chk("R3 no irq", irq, 0); chk("R3 not matched", matched, 0);
    bus_word(8'h99, 1'b0);
    chk("R3 data unchanged", data, 8'hC5); chk("R3 buf unchanged", bufw, 9'h18B);
    bus_stop();
  endtask

  task automatic t_gcall();
    bus_start();
    bus_word(8'h00, 1'b0);
    chk("R4 gcall disabled", irq, 0);
    bus_stop();
    slots[3] = 8'h01;
    bus_start();
    bus_word(8'h00, 1'b0);
    chk("R4 gcall irq", irq, 1); chk("R4 gcall matched", matched, 1);
    clear_irq();
    bus_stop();
    slots[3] = 8'h00;
  endtask

  task automatic t_match_all();
    match_all = 1'b1;
    bus_start();
    bus_word(8'hEE, 1'b0);
    chk("R5 any addr irq", irq, 1); chk("R5 data", data, 8'hEE);
    clear_irq();
    bus_stop();
    mon_en = 1'b0;
    bus_start();
    bus_word(8'hA0, 1'b0);
    chk("R6 off no irq", irq, 0); chk("R6 off no match", matched, 0);
    bus_word(8'h12, 1'b0);
    chk("R6 off data unchanged", data, 8'hEE);
    bus_stop();
    mon_en = 1'b1;
    match_all = 1'b0;
  endtask

  task automatic t_read();
    bus_start();
    bus_word(8'hA1, 1'b0);
    chk("R2 read dir", dir, 1); chk("R2 read irq", irq, 1);
    clear_irq();
    bus_word(8'h5A, 1'b0);
    chk("R8 read data", data, 8'h5A); chk("R8 read irq", irq, 1);
    clear_irq();
    bus_word(8'h96, 1'b1);
    chk("R8 nack byte", data, 8'h96); chk("R8 nack buf", bufw, 9'h12D);
    clear_irq();
    bus_word(8'h11, 1'b1);
    chk("R8 after nack no irq", irq, 0); chk("R8 after nack data", data, 8'h96);
    bus_start();
    bus_word(8'hA0, 1'b0);
    chk("R9 rstart irq", irq, 1); chk("R9 rstart dir", dir, 0);
    chk("R9 rstart data", data, 8'hA0);
    clear_irq();
    bus_stop();
    chk("R9 matched dropped", matched, 0);
  endtask

  initial begin
    wait_clk(3);
    t_reset();
    rst_n = 1'b1;
    slots[0] = 8'hA0;
    mon_en = 1'b1;
    wait_clk(4);
    t_write_match();
    t_no_match();
    t_gcall();
    t_match_all();
    t_read();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule